// File: doc/BRIEF.md
# Window Watchdog Supervisor with Reset Generator

This block watches over a host microcontroller. It drives an active-low reset toward the host and looks for rising edges on a watchdog trigger line. All timing is counted in pulses of a prescaled oscillator tick. When power becomes good, reset is held low for a long start interval and then released. The block then allows a lead interval in which the host must deliver its first trigger. If that trigger never comes, the whole start sequence runs again.

After the first trigger the block repeats a two-part window. A closed part comes first, and any trigger there is a fault. An open part follows, and a trigger there is the expected one. A trigger in the open part restarts the window. A trigger in the closed part, or no trigger before the open part ends, gives a short reset pulse, after which the lead interval runs again. A flag reports that at least one valid trigger has been accepted since the last reset. A power-good input forces reset at once and restarts the start sequence.

Top module: `wwdg_supervisor`

## Requirements
- R1: While the reset output is low and power-good is high, the valid-trigger flag is 0. After system reset, the reset output is low and the flag is 0.
- R2: After system reset or a power-good loss, the reset output stays low for exactly POR_TICKS tick pulses and then goes high.
- R3: A rising edge on the trigger during the lead interval sets the valid-trigger flag on the next clock and starts the closed part.
- R4: If no rising edge arrives within LEAD_TICKS tick pulses of the lead interval, the reset output goes low and the long POR_TICKS start sequence repeats.
- R5: A rising edge during the closed part (CLOSED_TICKS ticks) drives the reset output low for SHORT_TICKS ticks, clears the flag, and then starts a new lead interval.
- R6: If the open part (OPEN_TICKS ticks) ends without a rising edge, the block gives the same short reset as in R5.
- R7: A rising edge in the open part keeps reset high, keeps the flag at 1, and restarts the window at the start of the closed part.
- R8: Only a 0-to-1 change on the trigger counts. A held-high level or a falling edge has no effect.
- R9: Trigger edges while the reset output is low are ignored.
- R10: A low power-good drives the reset output low in the same cycle. It clears the flag on the next clock and restarts the R2 sequence once power-good returns.
- R11: Interval counters advance only on clocks where tick is 1. Changing the tick rate stretches every interval to match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous system reset, active low |
| pwr_good | input | 1 | Supply good flag; low forces host reset |
| tick | input | 1 | One-clock pulse of the prescaled oscillator |
| wd_trig | input | 1 | Watchdog trigger from the host, synchronous to clk |
| rst_out_n | output | 1 | Reset to the host, active low |
| trig_valid | output | 1 | At least one valid trigger accepted since the last reset |

## Verification
The properties assume that the trigger and tick inputs are already synchronous to clk and change only between clock edges. They also assume that tick is a single-clock pulse. The bench drives every input shortly after the falling edge, so each value is stable at the next rising edge. The bench uses shortened interval parameters so that each phase is crossed many times. Its trigger pulses are each at least one clock wide, so every intended rising edge is seen exactly once.

// File: rtl/wwdg_supervisor.sv
module wwdg_supervisor #(
  parameter int POR_TICKS    = 7000,
  parameter int LEAD_TICKS   = 7000,
  parameter int CLOSED_TICKS = 980,
  parameter int OPEN_TICKS   = 780,
  parameter int SHORT_TICKS  = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic tick,
  input  logic wd_trig,
  output logic rst_out_n,
  output logic trig_valid
);

  localparam int M1   = (POR_TICKS > LEAD_TICKS) ? POR_TICKS : LEAD_TICKS;
  localparam int M2   = (CLOSED_TICKS > OPEN_TICKS) ? CLOSED_TICKS : OPEN_TICKS;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXT = (M3 > SHORT_TICKS) ? M3 : SHORT_TICKS;
  localparam int CW   = $clog2(MAXT + 1);

  typedef enum logic [2:0] {PH_POR, PH_LEAD, PH_CLOSED, PH_OPEN, PH_SHORT} phase_t;

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          trig_q;
  logic          edge_seen;
  logic          done;

  assign edge_seen = wd_trig & ~trig_q;
  assign done      = tick && (cnt == last);
  assign rst_out_n = pwr_good && (phase != PH_POR) && (phase != PH_SHORT);

  always_comb begin
    case (phase)
      PH_POR:    last = CW'(POR_TICKS - 1);
      PH_LEAD:   last = CW'(LEAD_TICKS - 1);
      PH_CLOSED: last = CW'(CLOSED_TICKS - 1);
      PH_OPEN:   last = CW'(OPEN_TICKS - 1);
      default:   last = CW'(SHORT_TICKS - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase      <= PH_POR;
      cnt        <= '0;
      trig_q     <= 1'b0;
      trig_valid <= 1'b0;
    end else begin
      trig_q <= wd_trig;
      if (!pwr_good) begin
        phase      <= PH_POR;
        cnt        <= '0;
        trig_valid <= 1'b0;
      end else begin
        case (phase)
          PH_LEAD, PH_OPEN: begin
            if (edge_seen) begin
              phase      <= PH_CLOSED;
              cnt        <= '0;
              trig_valid <= 1'b1;
            end else if (done) begin
              phase <= (phase == PH_LEAD) ? PH_POR : PH_SHORT;
              cnt   <= '0;
              if (phase == PH_OPEN) trig_valid <= 1'b0;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          PH_CLOSED: begin
            if (edge_seen) begin
              phase      <= PH_SHORT;
              cnt        <= '0;
              trig_valid <= 1'b0;
            end else if (done) begin
              phase <= PH_OPEN;
              cnt   <= '0;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
          default: begin
            if (done) begin
              phase <= PH_LEAD;
              cnt   <= '0;
            end else if (tick) begin
              cnt <= cnt + 1'b1;
            end
          end
        endcase
      end
    end
  end

endmodule

module wwdg_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic pwr_good,
  input logic tick,
  input logic wd_trig,
  input logic rst_out_n,
  input logic trig_valid
);

  // R1
  valid_low_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !rst_out_n) |-> !trig_valid);

  // R10
  pg_loss_holds_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !rst_out_n);

  // R3
  valid_rise_needs_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_valid) |-> ($past(wd_trig) && $past(rst_out_n)));

  // R11
  release_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_out_n) |-> $past(tick));

  // R8
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && $past(pwr_good) && $fell(rst_out_n))
      |-> ($past(tick) || ($past(wd_trig) && !$past(wd_trig, 2))));

  // R9
  edges_ignored_in_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !rst_out_n) |=> !trig_valid);

endmodule

bind wwdg_supervisor wwdg_supervisor_chk u_chk (.*);

// File: tb/wwdg_supervisor_tb.sv
module wwdg_supervisor_tb;

  localparam int POR_T = 40, LEAD_T = 30, CLOSED_T = 20, OPEN_T = 16, SHORT_T = 8;

  logic clk = 0, rst_n = 0, pwr_good = 1, tick = 0, wd_trig = 0;
  logic rst_out_n, trig_valid;
  int   checks = 0, failures = 0, tick_div = 1, cyc = 0;
  bit   finished = 0;

  wwdg_supervisor #(.POR_TICKS(POR_T), .LEAD_TICKS(LEAD_T), .CLOSED_TICKS(CLOSED_T),
                    .OPEN_TICKS(OPEN_T), .SHORT_TICKS(SHORT_T)) u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .tick(tick), .wd_trig(wd_trig),
    .rst_out_n(rst_out_n), .trig_valid(trig_valid));

  always #5 clk = ~clk;

  always @(negedge clk) begin
    #1;
    tick <= (cyc % tick_div) == 0;
    cyc  <= cyc + 1;
  end

  // reference model: phase 0 start,1 lead,2 closed,3 open,4 short
  int m_phase = 0, m_left = POR_T, m_valid = 0, m_prev = 0;

  always @(posedge clk) begin
    int rise;
    if (!rst_n) begin
      m_phase = 0; m_left = POR_T; m_valid = 0; m_prev = 0;
    end else begin
      rise = (wd_trig && !m_prev) ? 1 : 0;
      m_prev = wd_trig;
      if (!pwr_good) begin
        m_phase = 0; m_left = POR_T; m_valid = 0;
      end else if ((m_phase == 1 || m_phase == 3) && rise == 1) begin
        m_phase = 2; m_left = CLOSED_T; m_valid = 1;
      end else if (m_phase == 2 && rise == 1) begin
        m_phase = 4; m_left = SHORT_T; m_valid = 0;
      end else if (tick) begin
        m_left = m_left - 1;
        if (m_left == 0) begin
          case (m_phase)
            0: begin m_phase = 1; m_left = LEAD_T; end
            1: begin m_phase = 0; m_left = POR_T; end
            2: begin m_phase = 3; m_left = OPEN_T; end
            3: begin m_phase = 4; m_left = SHORT_T; m_valid = 0; end
            default: begin m_phase = 1; m_left = LEAD_T; end
          endcase
        end
      end
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      int exp_rst;
      string tag;
      exp_rst = (pwr_good && m_phase != 0 && m_phase != 4) ? 1 : 0;
      case (m_phase)
        0: tag = "R2"; 1: tag = "R4"; 2: tag = "R5"; 3: tag = "R6"; default: tag = "R5";
      endcase
      if (!pwr_good) tag = "R10";
      check(rst_out_n == exp_rst, tag, rst_out_n, exp_rst);
      check(trig_valid == m_valid, "R7", trig_valid, m_valid);
    end
  end

  task automatic wait_ticks(input int n);
    int k = 0;
    while (k < n) begin
      @(posedge clk);
      if (tick) k++;
    end
    @(negedge clk); #1;
  endtask

  task automatic wait_release();
    do @(negedge clk); while (!rst_out_n);
    #1;
  endtask

  task automatic pulse();
    @(negedge clk); #1 wd_trig = 1;
    @(negedge clk); #1 wd_trig = 0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    check(rst_out_n == 0 && trig_valid == 0, "R1", rst_out_n, 0);

    wait_release();
    check(rst_out_n == 1, "R2", rst_out_n, 1);
    wait_ticks(LEAD_T + 1);
    check(rst_out_n == 0, "R4", rst_out_n, 0);

    pulse(); pulse(); pulse();
    check(trig_valid == 0 && rst_out_n == 0, "R9", trig_valid, 0);
    wait_release();

    pulse();
    check(trig_valid == 1, "R3", trig_valid, 1);

    wait_ticks(5);
    pulse();
    check(rst_out_n == 0 && trig_valid == 0, "R5", rst_out_n, 0);
    wait_release();

    pulse();
    wait_ticks(CLOSED_T + 3);
    pulse();
    wait_ticks(CLOSED_T - 2);
    check(rst_out_n == 1 && trig_valid == 1, "R7", rst_out_n, 1);

    wait_ticks(OPEN_T + 6);
    check(rst_out_n == 0, "R6", rst_out_n, 0);
    wait_release();

    @(negedge clk); #1 wd_trig = 1;
    wait_ticks(CLOSED_T + 3);
    check(rst_out_n == 1 && trig_valid == 1, "R8", rst_out_n, 1);
    wd_trig = 0;
    wait_ticks(2);
    check(rst_out_n == 1 && trig_valid == 1, "R8", rst_out_n, 1);
    wd_trig = 1;
    wait_ticks(5);
    wd_trig = 0;
    check(rst_out_n == 1, "R8", rst_out_n, 1);

    tick_div = 3;
    wait_ticks(CLOSED_T + 2);
    pulse();
    check(rst_out_n == 1 && trig_valid == 1, "R11", trig_valid, 1);
    wait_ticks(CLOSED_T + OPEN_T + 2);
    check(rst_out_n == 0, "R11", rst_out_n, 0);
    tick_div = 1;
    wait_release();
    pulse();

    wait_ticks(3);
    pwr_good = 0;
    #1 check(rst_out_n == 0, "R10", rst_out_n, 0);
    repeat (3) @(negedge clk);
    #1 pwr_good = 1;
    check(trig_valid == 0, "R10", trig_valid, 0);
    wait_release();
    check(rst_out_n == 1, "R2", rst_out_n, 1);

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule